// File: doc/BRIEF.md
# Write-Matching Test Counter

This block is a small register target that a host uses to probe how its write path behaves. It answers on two address windows, a memory window of 4096 bytes and an I/O window of 256 bytes. Writing a small selector value to offset 0 in either window arms one of six test slots. The slot is picked by the window the selector write came through and by the value written. Once a slot is armed, writes to its trigger address are qualified according to the slot's test kind and counted in a 32-bit counter.

The armed slot presents a read-only header that the host reads one byte per access. The header holds the slot's identity, its trigger address, its match byte, the live counter and a NUL-terminated text name. Slots of the "any data" and "exact data" kinds also raise a pending-notification output on every counted write. A header read or a new arming clears that output.

Bus accesses are single-cycle and carry a valid strobe, a write enable, a window select, a 12-bit byte address, a 2-bit size code, and 8-bit write and read data. Read data is registered.

Top module: `wmc_top`

## Requirements
- R1: After reset no slot is armed, `notify_pending` is 0, and every read returns 0 until a slot is armed.
- R2: A write to offset 0 of a window first disarms any armed slot. If the written value v is below 3, the slot with index (window × 3 + v) is armed, where window 0 is memory and window 1 is I/O. Arming clears the counter and `notify_pending`. A value of 3 or more leaves no slot armed.
- R3: Header bytes of the armed slot at these offsets: 0 holds the slot index, 1 holds the value 1, 2, 3 and 9 to 11 are zero, and 8 holds the match byte. Offsets 4 to 7 hold the trigger address as a little-endian 32-bit value. The trigger address is 2048 + index for slots 0 to 2 and 128 + index for slots 3 to 5. The match byte is 0xCE for kind 1 and 0xFA for kinds 0 and 2, where kind = index mod 3.
- R4: From header offset 16 on, the header holds an ASCII name followed by a NUL byte. The name is "mmio-" for slots 0 to 2 or "portio-" for slots 3 to 5, followed by "no-eventfd" for kind 0, "wildcard-eventfd" for kind 1 or "datamatch-eventfd" for kind 2. The header length is 17 plus the name length.
- R5: When the armed slot is of kind 1, every write to its trigger address counts, whatever its size code and data.
- R6: When the armed slot is of kind 0 or kind 2, a write to the trigger address counts only if its size code is 0 (one byte) and its data is 0xFA.
- R7: No other write changes the counter. This covers writes while nothing is armed, writes to addresses other than offset 0 and the trigger, and non-qualifying trigger writes.
- R8: Each counted write adds exactly one to the counter, modulo 2^32. Header bytes 12 to 15 expose the counter little-endian, and a read issued in the cycle after a counted write already shows the new value.
- R9: A read returns 0 when address + 2^size ≥ header length. Size code s means 2^s bytes. Otherwise it returns the single header byte at the address.
- R10: A counted write sets `notify_pending` for kinds 1 and 2 and never for kind 0. A read of the armed slot that returns a header byte clears it.
- R11: `bus_rdata` carries the result of a read in the cycle after the read is presented, and is 0 in every cycle that follows a non-read cycle.
- R12: I/O window accesses at addresses 256 and above are outside the window: writes there have no effect and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = memory window, 1 = I/O window |
| bus_addr | input | 12 | Byte address within the window |
| bus_size | input | 2 | Access size code, 2^code bytes |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| notify_pending | output | 1 | Counted-write notification flag |

## Verification
Arming, counting and the pending flag all take effect on the clock edge that samples the write. Read data appears one edge later, on the edge that samples the read. The bench drives each access at a falling edge and advances its behavioural model just after the next rising edge. It then compares `bus_rdata` and `notify_pending` at the following falling edge, so each check lands one full cycle after the stimulus. Reads placed directly after counted writes and arming writes confirm the same-next-cycle visibility of the counter and the clearing of the flag.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
    localparam int unsigned KINDS    = 3;
    localparam int unsigned NSLOTS   = 2 * KINDS;
    localparam int unsigned SLOT_W   = $clog2(NSLOTS);
    localparam int unsigned CNT_W    = 32;
    localparam int unsigned NAME_OFF = 16;
    localparam int unsigned STR_W    = 8 * 24;

    typedef enum logic [1:0] {
        KIND_QUIET = 2'd0,
        KIND_ANY   = 2'd1,
        KIND_EXACT = 2'd2
    } kind_e;

    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  count;
        logic              pending;
        logic [7:0]        rdata;
    } wmc_state_t;

    function automatic logic is_io_slot(input logic [SLOT_W-1:0] slot);
        return 32'(slot) >= KINDS;
    endfunction

    function automatic kind_e kind_of(input logic [SLOT_W-1:0] slot);
        logic [SLOT_W-1:0] k;
        k = is_io_slot(slot) ? slot - SLOT_W'(KINDS) : slot;
        return kind_e'(k[1:0]);
    endfunction

    function automatic logic [31:0] trig_of(input logic [SLOT_W-1:0] slot,
                                            input logic [31:0] mem_base,
                                            input logic [31:0] io_base);
        return (is_io_slot(slot) ? io_base : mem_base) + 32'(slot);
    endfunction

    function automatic logic [7:0] pick(input logic [STR_W-1:0] s,
                                        input int unsigned len,
                                        input int unsigned pos);
        return s[8*(len-1-pos) +: 8];
    endfunction

    function automatic int unsigned prefix_len(input logic [SLOT_W-1:0] slot);
        return is_io_slot(slot) ? 7 : 5;
    endfunction

    function automatic int unsigned kind_len(input kind_e k);
        case (k)
            KIND_ANY:   return 16;
            KIND_EXACT: return 17;
            default:    return 10;
        endcase
    endfunction

    function automatic int unsigned name_len(input logic [SLOT_W-1:0] slot);
        return prefix_len(slot) + kind_len(kind_of(slot));
    endfunction

    function automatic logic [7:0] name_char(input logic [SLOT_W-1:0] slot,
                                             input int unsigned pos);
        int unsigned plen;
        int unsigned p2;
        kind_e       k;
        plen = prefix_len(slot);
        k    = kind_of(slot);
        if (pos < plen) begin
            return is_io_slot(slot) ? pick(STR_W'("portio-"), 7, pos)
                                    : pick(STR_W'("mmio-"), 5, pos);
        end
        p2 = pos - plen;
        if (p2 >= kind_len(k)) return 8'h00;
        case (k)
            KIND_ANY:   return pick(STR_W'("wildcard-eventfd"), 16, p2);
            KIND_EXACT: return pick(STR_W'("datamatch-eventfd"), 17, p2);
            default:    return pick(STR_W'("no-eventfd"), 10, p2);
        endcase
    endfunction
endpackage

// File: rtl/wmc_decode.sv
module wmc_decode
    import wmc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned MEM_SPAN    = 4096,
    parameter int unsigned IO_SPAN     = 256,
    parameter int unsigned MEM_BASE    = 2048,
    parameter int unsigned IO_BASE     = 128,
    parameter logic [7:0]  MATCH_EXACT = 8'hFA
) (
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic              bus_win,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [7:0]        bus_wdata,
    input  logic              active,
    input  logic [SLOT_W-1:0] slot,
    output logic              in_win,
    output logic              sel_wr,
    output logic              sel_ok,
    output logic [SLOT_W-1:0] sel_slot,
    output logic              qual,
    output logic              notify,
    output logic              rd_en
);
    logic  wr_en;
    logic  trig_hit;
    kind_e kind;

    always_comb begin
        in_win   = bus_win ? (32'(bus_addr) < IO_SPAN) : (32'(bus_addr) < MEM_SPAN);
        wr_en    = bus_valid && bus_we && in_win;
        rd_en    = bus_valid && !bus_we && in_win;
        sel_wr   = wr_en && (bus_addr == '0);
        sel_ok   = 32'(bus_wdata) < KINDS;
        sel_slot = (bus_win ? SLOT_W'(KINDS) : '0) + bus_wdata[SLOT_W-1:0];
        kind     = kind_of(slot);
        trig_hit = wr_en && !sel_wr && active &&
                   (32'(bus_addr) == trig_of(slot, MEM_BASE, IO_BASE));
        qual     = trig_hit &&
                   ((kind == KIND_ANY) || (bus_size == 2'd0 && bus_wdata == MATCH_EXACT));
        notify   = qual && (kind != KIND_QUIET);
    end
endmodule

// File: rtl/wmc_header.sv
module wmc_header
    import wmc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned MEM_BASE    = 2048,
    parameter int unsigned IO_BASE     = 128,
    parameter logic [7:0]  MATCH_EXACT = 8'hFA,
    parameter logic [7:0]  MATCH_ANY   = 8'hCE
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] offset,
    output logic [7:0]        byte_o,
    output logic [ADDR_W:0]   hdr_len
);
    localparam int unsigned LW = ADDR_W + 1;

    int unsigned off;
    logic [31:0] trig;

    always_comb begin
        off     = 32'(offset);
        trig    = trig_of(slot, MEM_BASE, IO_BASE);
        hdr_len = LW'(NAME_OFF + name_len(slot) + 1);
        byte_o  = 8'h00;
        if (off == 0) begin
            byte_o = 8'(slot);
        end else if (off == 1) begin
            byte_o = 8'd1;
        end else if (off >= 4 && off <= 7) begin
            byte_o = trig[8*(off-4) +: 8];
        end else if (off == 8) begin
            byte_o = (kind_of(slot) == KIND_ANY) ? MATCH_ANY : MATCH_EXACT;
        end else if (off >= 12 && off <= 15) begin
            byte_o = count[8*(off-12) +: 8];
        end else if (off >= NAME_OFF) begin
            byte_o = name_char(slot, off - NAME_OFF);
        end
    end
endmodule

// File: rtl/wmc_top.sv
module wmc_top
    import wmc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned MEM_SPAN    = 4096,
    parameter int unsigned IO_SPAN     = 256,
    parameter int unsigned MEM_BASE    = 2048,
    parameter int unsigned IO_BASE     = 128,
    parameter logic [7:0]  MATCH_EXACT = 8'hFA,
    parameter logic [7:0]  MATCH_ANY   = 8'hCE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic              bus_win,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              notify_pending
);
    localparam int unsigned LW = ADDR_W + 1;

    wmc_state_t        st_d, st_q;
    logic              in_win, sel_wr, sel_ok, qual, notify, rd_en, in_range;
    logic [SLOT_W-1:0] sel_slot;
    logic [7:0]        hdr_byte;
    logic [ADDR_W:0]   hdr_len;

    wmc_decode #(
        .ADDR_W(ADDR_W), .MEM_SPAN(MEM_SPAN), .IO_SPAN(IO_SPAN),
        .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE), .MATCH_EXACT(MATCH_EXACT)
    ) u_decode (
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_win(bus_win),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .active(st_q.active), .slot(st_q.slot),
        .in_win(in_win), .sel_wr(sel_wr), .sel_ok(sel_ok), .sel_slot(sel_slot),
        .qual(qual), .notify(notify), .rd_en(rd_en)
    );

    wmc_header #(
        .ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE),
        .MATCH_EXACT(MATCH_EXACT), .MATCH_ANY(MATCH_ANY)
    ) u_header (
        .slot(st_q.slot), .count(st_q.count), .offset(bus_addr),
        .byte_o(hdr_byte), .hdr_len(hdr_len)
    );

    always_comb begin
        in_range = ({1'b0, bus_addr} + (LW'(1) << bus_size)) < hdr_len;
        st_d       = st_q;
        st_d.rdata = 8'h00;
        if (sel_wr) begin
            st_d.active  = sel_ok;
            st_d.pending = 1'b0;
            if (sel_ok) begin
                st_d.slot  = sel_slot;
                st_d.count = '0;
            end
        end else if (qual) begin
            st_d.count = st_q.count + 1'b1;
            if (notify) st_d.pending = 1'b1;
        end
        if (rd_en && st_q.active && in_range) begin
            st_d.rdata   = hdr_byte;
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata      = st_q.rdata;
    assign notify_pending = st_q.pending;

    // R2: an arming write leaves the slot armed with a zero counter
    assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && sel_ok) |=> (st_q.active && st_q.count == '0 && !notify_pending));

    // R2: a selector of 3 or more leaves nothing armed
    assert_disarm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !sel_ok) |=> !st_q.active);

    // R7: a non-counting write never moves the counter
    assert_ignored_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && !sel_wr && !qual) |=> $stable(st_q.count));

    // R10: quiet-kind slots never raise the notification
    assert_quiet_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && kind_of(st_q.slot) == KIND_QUIET) |-> !notify_pending);

    // R1: with nothing armed there is nothing pending
    assert_idle_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> !notify_pending);

    // R11: read data is zero after any non-read cycle
    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_we) |=> (bus_rdata == 8'h00));

    // R12: out-of-window I/O writes leave the armed state untouched
    assert_io_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && !in_win) |=> ($stable(st_q.active) && $stable(st_q.count)));
endmodule

// File: tb/sim_wmc_top.sv
module sim_wmc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0, bus_we = 1'b0, bus_win = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0] bus_size = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       notify_pending;

    always #4 clk = ~clk;

    wmc_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_win(bus_win), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .notify_pending(notify_pending)
    );

    int          checks = 0, fails = 0;
    string       cur_req = "R1";
    bit          done = 0;
    bit          m_act = 0;
    int          m_slot = 0;
    int unsigned m_cnt = 0;
    bit          m_pend = 0;
    int          exp_rd = 0;

    function automatic string nm(int s);
        string kinds[3] = '{"no-eventfd", "wildcard-eventfd", "datamatch-eventfd"};
        return {(s >= 3) ? "portio" : "mmio", "-", kinds[s % 3]};
    endfunction

    function automatic int hlen(int s);
        string n = nm(s);
        return 17 + n.len();
    endfunction

    function automatic int trig(int s);
        return ((s >= 3) ? 128 : 2048) + s;
    endfunction

    function automatic int hbyte(int s, int off, int unsigned cnt);
        string n = nm(s);
        if (off == 0) return s;
        if (off == 1) return 1;
        if (off >= 4 && off <= 7) return (trig(s) >> (8 * (off - 4))) & 255;
        if (off == 8) return (s % 3 == 1) ? 'hCE : 'hFA;
        if (off >= 12 && off <= 15) return int'((cnt >> (8 * (off - 12))) & 255);
        if (off >= 16 && off - 16 < n.len()) return int'(n[off - 16]);
        return 0;
    endfunction

    task automatic model(bit v, bit we, bit win, int addr, int size, int data);
        bit inw = !(win && addr >= 256);
        exp_rd = 0;
        if (!v || !inw) return;
        if (we) begin
            if (addr == 0) begin
                m_act = 0;
                m_pend = 0;
                if (data < 3) begin
                    m_act = 1; m_slot = (win ? 3 : 0) + data; m_cnt = 0;
                end
            end else if (m_act && addr == trig(m_slot)) begin
                if (m_slot % 3 == 1 || (size == 0 && data == 'hFA)) begin
                    m_cnt = m_cnt + 1;
                    if (m_slot % 3 != 0) m_pend = 1;
                end
            end
        end else if (m_act && addr + (1 << size) < hlen(m_slot)) begin
            exp_rd = hbyte(m_slot, addr, m_cnt);
            m_pend = 0;
        end
    endtask

    task automatic compare();
        checks++;
        if (bus_rdata !== exp_rd[7:0]) begin
            fails++;
            $display("FAIL %s rdata actual=%0h expected=%0h", cur_req, bus_rdata, exp_rd[7:0]);
        end
        checks++;
        if (notify_pending !== m_pend) begin
            fails++;
            $display("FAIL %s pending actual=%0b expected=%0b", cur_req, notify_pending, m_pend);
        end
    endtask

    task automatic cyc(bit v, bit we, bit win, int addr, int size, int data);
        bus_valid = v; bus_we = we; bus_win = win;
        bus_addr = 12'(addr); bus_size = 2'(size); bus_wdata = 8'(data);
        @(posedge clk);
        #1 model(v, we, win, addr, size, data);
        @(negedge clk);
        bus_valid = 0;
        compare();
    endtask

    task automatic wr(bit win, int addr, int data, int size = 0);
        cyc(1, 1, win, addr, size, data);
    endtask

    task automatic rd(bit win, int addr, int size = 0);
        cyc(1, 0, win, addr, size, 0);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare();
        rst_n = 1;
        @(negedge clk);
        rd(0, 0); rd(1, 0); rd(0, 12);
        cur_req = "R7";
        wr(0, 2048, 'hFA); wr(1, 131, 'hCE);
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 3; s++) begin
                int sl = w * 3 + s;
                int t  = trig(sl);
                cur_req = "R2"; wr(w[0], 0, s); rd(w[0], 12);
                cur_req = "R3"; for (int o = 0; o < 16; o++) rd(w[0], o);
                cur_req = "R4"; for (int o = 16; o < 46; o++) rd(w[0], o);
                cur_req = (s == 1) ? "R5" : "R6";
                wr(w[0], t, 'hFA); rd(w[0], 12);
                wr(w[0], t, 'hFA, 1); idle();
                wr(w[0], t, 'h00); idle();
                wr(w[0], t, 'hCE, 2); rd(w[0], 12);
                cur_req = "R10";
                wr(w[0], t, 'hFA); idle(); idle(); rd(w[0], 1); idle();
                cur_req = "R7";
                wr(w[0], t + 1, 'hFA); wr(w[0], 5, 'hFA); rd(w[0], 12);
                cur_req = "R9";
                rd(w[0], hlen(sl) - 1); rd(w[0], hlen(sl) - 2);
                rd(w[0], hlen(sl) - 2, 1); rd(w[0], hlen(sl) - 3, 1);
                rd(w[0], 0, 3); rd(w[0], hlen(sl) - 9, 3); rd(w[0], hlen(sl) - 8, 3);
                rd(w[0], 4000, 0);
            end
        end
        cur_req = "R8";
        wr(0, 0, 1);
        for (int i = 0; i < 300; i++) begin
            wr(0, 2049, i);
            if (i % 50 == 0) rd(0, 12);
        end
        rd(0, 12); rd(0, 13); rd(0, 14); rd(0, 15);
        cur_req = "R12";
        wr(1, 0, 2); wr(1, 256, 7); rd(1, 0); rd(1, 256); rd(1, 4095);
        wr(1, 256 + 133, 'hFA); wr(1, 133, 'hFA); rd(1, 12);
        cur_req = "R11";
        idle(); idle(); rd(1, 0); idle();
        cur_req = "R2";
        wr(1, 0, 3); rd(1, 0); rd(0, 0); wr(1, 133, 'hFA); rd(1, 12);
        wr(0, 0, 2); wr(0, 0, 255); rd(0, 0);
        wr(1, 0, 0); rd(1, 0); rd(0, 8);
        done = 1;
        summary();
        $finish;
    end
endmodule